// File: doc/BRIEF.md
# Master-Mode FIFO Memory Bus Sequencer

This block moves single bytes between an internal data path and an external memory that looks like a FIFO and takes no address. When enabled it acts as bus master. During decoding it runs read cycles and hands each captured byte to the internal side. During encoding it takes bytes from the internal side and runs write cycles. Each bus cycle lasts a programmable one to eight clocks. A busy input from the memory's control logic, sampled one clock ahead, can hold off the start of any cycle.

Chip-select marks a cycle and is asserted from the rising edge that starts it. The read or write strobe follows half a clock later and is released at the edge that ends the cycle. An address-advance strobe is low during the last clock of each executed cycle, so the memory can step its own pointer. When cycles run back to back, chip-select stays low without a gap. The cycle length and direction are taken when a cycle starts. The internal side offers write bytes with a valid/ready handshake and signals room for read bytes with a ready level. Each captured read byte appears as a one-clock valid pulse.

Top module: `fifo_bus_master`

## Requirements
- R1: While `enable` is low (from the clock after it falls), no cycle starts even with work pending; `cs_n`, `oe_n`, `we_n`, `adv_n` are all high and `bus_oe` is low.
- R2: A cycle lasts `cyc_len`+1 clocks (0 gives 1, 7 gives 8). The value is taken at the edge that starts the cycle, and changing it mid-cycle has no effect on that cycle.
- R3: A cycle can start at rising edge k only if `mem_busy` (active high) was low when sampled at edge k-1. With busy high at that sample, no cycle starts.
- R4: `adv_n` is low during the final clock of every executed cycle and at no other time.
- R5: With work pending and busy low, a new cycle starts at the edge that ends the previous one, so `cs_n` stays low for exactly (number of cycles)×(`cyc_len`+1) consecutive clocks.
- R6: A read cycle (`dir_sel`=0) holds `oe_n` high in the first half of its first clock and low from then until the ending edge. `bus_in` is captured at that edge, and `rd_valid` is high for the following clock with the byte on `rd_data`, in memory order.
- R7: A write cycle (`dir_sel`=1) holds `we_n` high in the first half of its first clock and low from then until the ending edge. `bus_oe` is high and `bus_out` holds the byte for the whole cycle. Bytes are taken when `wr_valid` and `wr_ready` are both high at a rising edge, and they reach the bus in that order. `oe_n` and `we_n` are never low together.
- R8: A cycle is attempted only when work is pending (`wr_valid` for writes, `rd_ready` for reads), and each start executes exactly one transfer.
- R9: The direction is taken at the start of a cycle, and changing `dir_sel` mid-cycle does not alter that cycle's strobes.
- R10: Clearing `enable` during a cycle ends it at the next rising edge with no `adv_n` pulse.
- R11: After reset all strobes are high, `bus_oe`, `rd_valid` and `wr_ready` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Master enable |
| dir_sel | input | 1 | 1 = write (encode), 0 = read (decode) |
| cyc_len | input | CYC_W | Cycle length minus one |
| wr_valid | input | 1 | Internal write byte available |
| wr_data | input | DATA_W | Internal write byte |
| wr_ready | output | 1 | Write byte accepted at this edge when valid |
| rd_ready | input | 1 | Internal side has room for a read byte |
| rd_valid | output | 1 | Read byte present on rd_data |
| rd_data | output | DATA_W | Captured read byte |
| mem_busy | input | 1 | Memory temporarily unavailable |
| cs_n | output | 1 | Chip-select, active low |
| oe_n | output | 1 | Read strobe, active low |
| we_n | output | 1 | Write strobe, active low |
| adv_n | output | 1 | Address-advance strobe, active low |
| bus_out | output | DATA_W | Data driven toward memory |
| bus_oe | output | 1 | Drive enable for bus_out |
| bus_in | input | DATA_W | Data returned from memory |

## Verification
On every rising edge the assertions check several rules. The strobes stay quiet while disabled. Each cycle ends with its advance pulse exactly at the programmed length. No start follows a busy sample. The read and write strobes are never low together and never low outside chip-select. Write data holds steady within a cycle, and each read-valid pulse follows a completed read. The half-clock strobe delay, the absence of gaps between back-to-back cycles, the order of bytes through the queue-modelled memory, and the effect of mid-cycle changes to length, direction and enable can only be shown by the bench's scenarios. The bench samples both clock phases for these.

// File: rtl/fifo_bus_pkg.sv
package fifo_bus_pkg;

   typedef enum logic {
      DIR_RD = 1'b0,
      DIR_WR = 1'b1
   } xfer_dir_e;

   typedef struct packed {
      logic      active;
      logic      last;
      xfer_dir_e dir;
   } cyc_state_t;

endpackage

// File: rtl/fifo_bus_seq.sv
module fifo_bus_seq
   import fifo_bus_pkg::*;
#(
   parameter int CYC_W           = 3,
   parameter bit BUSY_ACTIVE_LOW = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             dir_sel,
   input  logic [CYC_W-1:0] cyc_len,
   input  logic             wr_valid,
   input  logic             rd_ready,
   input  logic             mem_busy,
   output logic             start,
   output logic             wr_ready,
   output cyc_state_t       cyc
);

   if (CYC_W < 1 || CYC_W > 6) begin : g_bad_cyc_w
      $error("fifo_bus_seq: CYC_W out of range");
   end

   logic busy_raw;
   if (BUSY_ACTIVE_LOW) begin : g_busy_low
      assign busy_raw = ~mem_busy;
   end else begin : g_busy_high
      assign busy_raw = mem_busy;
   end

   logic             busy_q;
   logic             active_q;
   logic [CYC_W-1:0] cnt_q;
   logic [CYC_W-1:0] len_q;
   xfer_dir_e        dir_q;
   xfer_dir_e        dir_in;
   logic             last;
   logic             boundary;
   logic             slot_open;
   logic             pending;

   assign dir_in    = xfer_dir_e'(dir_sel);
   assign last      = active_q && (cnt_q == len_q);
   assign boundary  = !active_q || last;
   assign slot_open = enable && boundary && !busy_q;
   assign pending   = (dir_in == DIR_WR) ? wr_valid : rd_ready;
   assign start     = slot_open && pending;
   assign wr_ready  = slot_open && (dir_in == DIR_WR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b1;
         active_q <= 1'b0;
         cnt_q    <= '0;
         len_q    <= '0;
         dir_q    <= DIR_RD;
      end else begin
         busy_q <= busy_raw;
         if (!enable) begin
            active_q <= 1'b0;
         end else if (boundary) begin
            active_q <= start;
            if (start) begin
               cnt_q <= '0;
               len_q <= cyc_len;
               dir_q <= dir_in;
            end
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign cyc.active = active_q;
   assign cyc.last   = last;
   assign cyc.dir    = dir_q;

endmodule

// File: rtl/fifo_bus_strobe.sv
module fifo_bus_strobe
   import fifo_bus_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  cyc_state_t cyc,
   output logic       oe_n,
   output logic       we_n
);

   // Rising-edge token flips at every start; the falling-edge copy
   // catches up half a clock later and opens the strobe window.
   logic tok_r;
   logic tok_f;
   logic settled;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tok_r <= 1'b0;
      else        tok_r <= tok_r ^ start;
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) tok_f <= 1'b0;
      else        tok_f <= tok_r;
   end

   assign settled = (tok_r == tok_f);
   assign oe_n    = !(cyc.active && settled && (cyc.dir == DIR_RD));
   assign we_n    = !(cyc.active && settled && (cyc.dir == DIR_WR));

endmodule

// File: rtl/fifo_bus_dpath.sv
module fifo_bus_dpath
   import fifo_bus_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              start,
   input  logic              dir_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W-1:0] bus_in,
   input  cyc_state_t        cyc,
   output logic [DATA_W-1:0] bus_out,
   output logic              bus_oe,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);

   if (DATA_W < 1) begin : g_bad_data_w
      $error("fifo_bus_dpath: DATA_W must be positive");
   end

   logic [DATA_W-1:0] wbyte_q;
   logic              capture;

   assign capture = enable && cyc.last && (cyc.dir == DIR_RD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wbyte_q  <= '0;
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         if (start && dir_sel) wbyte_q <= wr_data;
         rd_valid <= capture;
         if (capture) rd_data <= bus_in;
      end
   end

   assign bus_out = wbyte_q;
   assign bus_oe  = cyc.active && (cyc.dir == DIR_WR);

endmodule

// File: rtl/fifo_bus_master.sv
module fifo_bus_master
   import fifo_bus_pkg::*;
#(
   parameter int DATA_W          = 8,
   parameter int CYC_W           = 3,
   parameter bit BUSY_ACTIVE_LOW = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              dir_sel,
   input  logic [CYC_W-1:0]  cyc_len,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_ready,
   input  logic              rd_ready,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   input  logic              mem_busy,
   output logic              cs_n,
   output logic              oe_n,
   output logic              we_n,
   output logic              adv_n,
   output logic [DATA_W-1:0] bus_out,
   output logic              bus_oe,
   input  logic [DATA_W-1:0] bus_in
);

   cyc_state_t cyc;
   logic       start;

   fifo_bus_seq #(
      .CYC_W           (CYC_W),
      .BUSY_ACTIVE_LOW (BUSY_ACTIVE_LOW)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (enable),
      .dir_sel  (dir_sel),
      .cyc_len  (cyc_len),
      .wr_valid (wr_valid),
      .rd_ready (rd_ready),
      .mem_busy (mem_busy),
      .start    (start),
      .wr_ready (wr_ready),
      .cyc      (cyc)
   );

   fifo_bus_strobe u_strobe (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .cyc   (cyc),
      .oe_n  (oe_n),
      .we_n  (we_n)
   );

   fifo_bus_dpath #(
      .DATA_W (DATA_W)
   ) u_dpath (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (enable),
      .start    (start),
      .dir_sel  (dir_sel),
      .wr_data  (wr_data),
      .bus_in   (bus_in),
      .cyc      (cyc),
      .bus_out  (bus_out),
      .bus_oe   (bus_oe),
      .rd_valid (rd_valid),
      .rd_data  (rd_data)
   );

   assign cs_n  = !cyc.active;
   assign adv_n = !cyc.last;

endmodule

// File: rtl/fifo_bus_master_chk.sv
module fifo_bus_master_chk #(
   parameter int DATA_W          = 8,
   parameter int CYC_W           = 3,
   parameter bit BUSY_ACTIVE_LOW = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              enable,
   input logic [CYC_W-1:0]  cyc_len,
   input logic              mem_busy,
   input logic              cs_n,
   input logic              oe_n,
   input logic              we_n,
   input logic              adv_n,
   input logic              bus_oe,
   input logic [DATA_W-1:0] bus_out,
   input logic              rd_valid
);

   logic             busy_eff;
   logic             prev_cs_n;
   logic             prev_adv_n;
   logic [CYC_W-1:0] len_d;
   logic [CYC_W:0]   run_idx;
   logic [CYC_W:0]   run_len;
   logic             is_new;
   logic [CYC_W:0]   cur_idx;
   logic [CYC_W:0]   cur_len;

   assign busy_eff = BUSY_ACTIVE_LOW ? ~mem_busy : mem_busy;
   assign is_new   = !cs_n && (prev_cs_n || !prev_adv_n);
   assign cur_idx  = is_new ? (CYC_W+1)'(1) : run_idx + 1'b1;
   assign cur_len  = is_new ? {1'b0, len_d} + 1'b1 : run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_cs_n  <= 1'b1;
         prev_adv_n <= 1'b1;
         len_d      <= '0;
         run_idx    <= '0;
         run_len    <= '0;
      end else begin
         prev_cs_n  <= cs_n;
         prev_adv_n <= adv_n;
         len_d      <= cyc_len;
         if (!cs_n) begin
            run_idx <= cur_idx;
            run_len <= cur_len;
         end
      end
   end

   p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(enable) |-> (cs_n && oe_n && we_n && adv_n && !bus_oe));

   p_cyc_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |-> ((!adv_n) == (cur_idx == cur_len)));

   p_busy_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      is_new |-> !$past(busy_eff, 2));

   p_adv_in_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !adv_n |-> !cs_n);

   p_strobe_in_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!oe_n || !we_n) |-> !cs_n);

   p_rd_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(!adv_n && !oe_n));

   p_we_oe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(!oe_n && !we_n));

   p_wdata_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_oe && !is_new) |-> $stable(bus_out));

endmodule

bind fifo_bus_master fifo_bus_master_chk #(
   .DATA_W          (DATA_W),
   .CYC_W           (CYC_W),
   .BUSY_ACTIVE_LOW (BUSY_ACTIVE_LOW)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .enable   (enable),
   .cyc_len  (cyc_len),
   .mem_busy (mem_busy),
   .cs_n     (cs_n),
   .oe_n     (oe_n),
   .we_n     (we_n),
   .adv_n    (adv_n),
   .bus_oe   (bus_oe),
   .bus_out  (bus_out),
   .rd_valid (rd_valid)
);

// File: tb/fifo_bus_master_tb.sv
module fifo_bus_master_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0;
   logic       dir_sel = 1'b1;
   logic [2:0] cyc_len = 3'd0;
   logic       wr_valid = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       wr_ready;
   logic       rd_ready = 1'b0;
   logic       rd_valid;
   logic [7:0] rd_data;
   logic       mem_busy = 1'b0;
   logic       cs_n, oe_n, we_n, adv_n, bus_oe;
   logic [7:0] bus_out;
   logic [7:0] bus_in = 8'h00;

   always #4 clk = ~clk;

   fifo_bus_master u_dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .dir_sel(dir_sel),
      .cyc_len(cyc_len), .wr_valid(wr_valid), .wr_data(wr_data),
      .wr_ready(wr_ready), .rd_ready(rd_ready), .rd_valid(rd_valid),
      .rd_data(rd_data), .mem_busy(mem_busy), .cs_n(cs_n), .oe_n(oe_n),
      .we_n(we_n), .adv_n(adv_n), .bus_out(bus_out), .bus_oe(bus_oe),
      .bus_in(bus_in)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // stimulus state
   int  cur_v = 0;
   int  wr_n = 0, wr_idx = 0;
   bit  wr_acc = 1'b0;
   int  rd_n = 0, rd_started = 0, rd_ptr = 0;
   bit  rd_adv = 1'b0;
   bit  busy_rand = 1'b0, busy_force = 1'b0;
   logic [7:0] wr_got[$];
   logic [7:0] rd_got[$];

   // monitor state
   int   mon_err = 0, mon_cycles = 0, mon_cs_clks = 0;
   int   idx = 0, exp_len = 1;
   logic exp_dir = 1'b0, prev_dir = 1'b0;
   logic prev_cs_n = 1'b1, prev_adv_n = 1'b1;
   logic [7:0] byte_hold = 8'h00;

   function automatic logic [7:0] wbyte(int v, int k);
      return 8'((k * 37 + v * 11 + 5) & 255);
   endfunction

   function automatic logic [7:0] rbyte(int v, int k);
      return 8'((k * 53 + v * 7 + 90) & 255);
   endfunction

   task automatic chk(bit ok, string req, string what, int act, int expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   task automatic merr(string what);
      mon_err++;
      if (mon_err < 10) $display("[TB] monitor mismatch at %0t: %s", $time, what);
   endtask

   task automatic mon_rise();
      bit newc, end_rd;
      logic st, ot;
      end_rd = !prev_cs_n && !prev_adv_n && (prev_dir == 1'b0);
      rd_adv = end_rd;
      if (rd_valid !== end_rd) merr("rd_valid timing (R6)");
      if (rd_valid) rd_got.push_back(rd_data);
      if (!cs_n) begin
         newc = prev_cs_n || !prev_adv_n;
         if (newc) begin
            idx = 1; exp_len = int'(cyc_len) + 1; exp_dir = dir_sel;
            byte_hold = bus_out;
            if (exp_dir == 1'b0) rd_started++;
         end else begin
            idx++;
         end
         mon_cs_clks++;
         if ((adv_n == 1'b0) != (idx == exp_len)) merr("adv position (R4/R2)");
         if (idx > exp_len) merr("cycle too long (R2)");
         st = exp_dir ? we_n : oe_n;
         ot = exp_dir ? oe_n : we_n;
         if (st != (idx == 1)) merr("strobe first half (R6/R7)");
         if (ot != 1'b1) merr("wrong strobe (R9)");
         if (bus_oe != exp_dir) merr("bus_oe (R7)");
         if (exp_dir && bus_out != byte_hold) merr("bus_out moved (R7)");
         if (!adv_n) mon_cycles++;
      end else begin
         idx = 0;
         if (!(oe_n && we_n && adv_n && !bus_oe)) merr("idle strobes (R1)");
      end
      prev_cs_n = cs_n; prev_adv_n = adv_n; prev_dir = exp_dir;
   endtask

   task automatic mon_fall();
      logic st;
      if (!cs_n) begin
         st = exp_dir ? we_n : oe_n;
         if (st !== 1'b0) merr("strobe second half (R6/R7)");
         if (exp_dir && !adv_n) wr_got.push_back(bus_out);
      end
   endtask

   task automatic drive();
      if (wr_acc) begin wr_idx++; wr_acc = 1'b0; end
      wr_valid = (wr_idx < wr_n);
      wr_data  = wbyte(cur_v, wr_idx);
      rd_ready = (rd_started < rd_n);
      if (rd_adv) rd_ptr++;
      bus_in   = rbyte(cur_v, rd_ptr);
      mem_busy = busy_rand ? (($urandom % 3) == 0) : busy_force;
   endtask

   // per-clock activity: +1 monitor, +2 drive, +5 second-half monitor, +7 handshake
   initial begin
      forever begin
         @(posedge clk);
         #1; if (rst_n) mon_rise();
         #1; drive();
         #3; if (rst_n) mon_fall();
         #2; if (wr_valid && wr_ready) wr_acc = 1'b1;
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual expired expected completion");
      finish_run();
   end

   task automatic at_cfg();
      @(posedge clk); #3;
   endtask

   task automatic at_obs();
      @(posedge clk); #1;
   endtask

   // {dir(1=write), len(3), count(5), random busy(1)}
   localparam int NV = 17;
   localparam logic [9:0] VEC [NV] = '{
      {1'b1, 3'd0, 5'd6, 1'b0}, {1'b1, 3'd1, 5'd5, 1'b0},
      {1'b1, 3'd2, 5'd4, 1'b1}, {1'b1, 3'd3, 5'd4, 1'b0},
      {1'b1, 3'd4, 5'd3, 1'b0}, {1'b1, 3'd5, 5'd2, 1'b0},
      {1'b1, 3'd6, 5'd2, 1'b0}, {1'b1, 3'd7, 5'd3, 1'b1},
      {1'b1, 3'd0, 5'd8, 1'b1}, {1'b0, 3'd0, 5'd6, 1'b0},
      {1'b0, 3'd1, 5'd5, 1'b0}, {1'b0, 3'd2, 5'd4, 1'b0},
      {1'b0, 3'd3, 5'd4, 1'b1}, {1'b0, 3'd4, 5'd3, 1'b1},
      {1'b0, 3'd5, 5'd3, 1'b0}, {1'b0, 3'd6, 5'd2, 1'b1},
      {1'b0, 3'd7, 5'd3, 1'b0}
   };

   initial begin
      int e0, c0, k0, bad;
      repeat (4) @(posedge clk);
      #3 rst_n = 1'b1;
      at_obs();
      // R11: reset state
      chk(cs_n && oe_n && we_n && adv_n, "R11", "strobes after reset",
          {cs_n, oe_n, we_n, adv_n}, 15);
      chk(!bus_oe && !rd_valid && !wr_ready, "R11", "bus_oe/rd_valid/wr_ready",
          {bus_oe, rd_valid, wr_ready}, 0);

      // R1: disabled with write work pending
      at_cfg(); dir_sel = 1'b1; cur_v = 40; wr_idx = 0; wr_n = 3;
      repeat (6) at_obs();
      chk(cs_n && we_n && adv_n && !bus_oe, "R1", "idle while disabled",
          {cs_n, we_n, adv_n, bus_oe}, 14);
      chk(wr_idx == 0 && mon_cycles == 0, "R1", "no transfer while disabled",
          wr_idx, 0);
      at_cfg(); wr_n = 0; enable = 1'b1;
      repeat (3) at_obs();

      // vector table
      for (int i = 0; i < NV; i++) begin
         logic       vd;
         logic [2:0] vl;
         int         vn;
         logic       vb;
         vd = VEC[i][9]; vl = VEC[i][8:6]; vn = int'(VEC[i][5:1]); vb = VEC[i][0];
         at_cfg();
         e0 = mon_err; c0 = mon_cycles; k0 = mon_cs_clks;
         cur_v = i; wr_idx = 0; rd_started = 0; rd_ptr = 0;
         wr_got.delete(); rd_got.delete();
         dir_sel = vd; cyc_len = vl; busy_rand = vb; busy_force = 1'b0;
         if (vd) wr_n = vn; else rd_n = vn;
         for (int t = 0; t < 3000; t++) begin
            @(posedge clk);
            if (vd && wr_got.size() >= vn) break;
            if (!vd && rd_got.size() >= vn) break;
         end
         repeat (4) @(posedge clk);
         #3 wr_n = 0; rd_n = 0; busy_rand = 1'b0;
         chk(mon_err == e0, vd ? "R7" : "R6", "strobe waveform errors",
             mon_err - e0, 0);
         bad = 0;
         if (vd) begin
            if (wr_got.size() != vn) bad++;
            else foreach (wr_got[j]) if (wr_got[j] != wbyte(i, j)) bad++;
            chk(bad == 0, "R7", "write bytes in order", wr_got.size(), vn);
         end else begin
            if (rd_got.size() != vn) bad++;
            else foreach (rd_got[j]) if (rd_got[j] != rbyte(i, j)) bad++;
            chk(bad == 0, "R6", "read bytes in order", rd_got.size(), vn);
         end
         chk(mon_cycles - c0 == vn, "R8", "one cycle per byte", mon_cycles - c0, vn);
         if (!vb)
            chk(mon_cs_clks - k0 == vn * (int'(vl) + 1), "R5",
                "back-to-back cs clocks", mon_cs_clks - k0, vn * (int'(vl) + 1));
      end

      // R3: busy sampled one clock ahead
      at_cfg(); busy_force = 1'b1; dir_sel = 1'b1; cyc_len = 3'd0;
      cur_v = 50; wr_idx = 0; wr_got.delete(); c0 = mon_cycles;
      repeat (3) at_obs();
      at_cfg(); wr_n = 1;
      repeat (4) at_obs();
      chk(cs_n == 1'b1 && mon_cycles == c0, "R3", "busy holds off start", cs_n, 1);
      at_cfg(); busy_force = 1'b0;
      at_obs();
      chk(cs_n == 1'b1, "R3", "no start one edge after release", cs_n, 1);
      at_obs();
      chk(cs_n == 1'b1, "R3", "no start until busy sampled low", cs_n, 1);
      at_obs();
      chk(cs_n == 1'b0, "R3", "start after busy sampled low", cs_n, 0);
      repeat (3) at_obs();
      chk(wr_got.size() == 1 && wr_got[0] == wbyte(50, 0), "R3",
          "gated byte written", wr_got.size(), 1);

      // R2: length change mid-cycle
      at_cfg(); cyc_len = 3'd7; cur_v = 51; wr_idx = 0; wr_n = 1; wr_got.delete();
      e0 = mon_err; c0 = mon_cycles; k0 = mon_cs_clks;
      for (int t = 0; t < 20 && cs_n; t++) at_obs();
      at_obs();
      at_cfg(); cyc_len = 3'd0;
      repeat (14) at_obs();
      chk(mon_cs_clks - k0 == 8, "R2", "length held at 8 clocks", mon_cs_clks - k0, 8);
      chk(mon_cycles - c0 == 1 && mon_err == e0, "R2", "single clean cycle",
          mon_err - e0, 0);

      // R9: direction change mid-cycle
      at_cfg(); cyc_len = 3'd3; dir_sel = 1'b1; cur_v = 52; wr_idx = 0; wr_n = 1;
      rd_n = 0; wr_got.delete(); e0 = mon_err;
      for (int t = 0; t < 20 && cs_n; t++) at_obs();
      at_cfg(); dir_sel = 1'b0;
      repeat (8) at_obs();
      chk(wr_got.size() == 1 && mon_err == e0, "R9", "write completes after dir change",
          mon_err - e0, 0);
      chk(wr_got.size() == 1 && wr_got[0] == wbyte(52, 0), "R9", "written byte",
          wr_got.size(), 1);
      at_cfg(); dir_sel = 1'b1;

      // R10: disable during a cycle
      at_cfg(); cyc_len = 3'd7; cur_v = 53; wr_idx = 0; wr_n = 1; wr_got.delete();
      c0 = mon_cycles;
      for (int t = 0; t < 20 && cs_n; t++) at_obs();
      at_obs();
      at_cfg(); enable = 1'b0;
      at_obs();
      chk(cs_n && we_n && adv_n && !bus_oe, "R10", "abort releases bus",
          {cs_n, we_n, adv_n, bus_oe}, 14);
      repeat (10) at_obs();
      chk(mon_cycles == c0 && wr_got.size() == 0, "R10", "no advance pulse on abort",
          mon_cycles - c0, 0);
      at_cfg(); enable = 1'b1;
      repeat (4) at_obs();
      chk(cs_n == 1'b1, "R8", "no cycle without pending work", cs_n, 1);

      finish_run();
   end

endmodule